// File: doc/BRIEF.md
# Conditional ALU with Sticky Flags

A single-cycle arithmetic, logic and shift datapath that keeps its own accumulator (ACC) and shift result register (SHF). Each operand can be taken from either of two register inputs, from ACC or from SHF. The block receives a decoded operation code and a condition code. It writes results and flags only when the condition is met. It also exposes the condition outcome as a combinational signal.

Two flag copies are kept. The stored flags are the architected flags and change only when the flag-write control is high. The current flags always follow the most recent committed flag-producing operation. The condition can be tested against either copy. In sticky mode a write to the stored flags can set bits but cannot clear them. Multiply-accumulate is built from one initialisation step followed by WIDTH/2 two-bit Booth steps. Division is built from WIDTH one-bit restoring steps. Both work through ACC, with SHF holding the multiplier or the dividend.

Top module: `cond_alu`

## Requirements
- R1: After reset, ACC, SHF, the stored flags, the current flags and the shifter carry are all zero. Flags are packed {N,Z,C,V} in bits 3..0.
- R2: Each operand select picks 0 = register A, 1 = register B, 2 = ACC, 3 = SHF. Operand X uses sel_x and operand Y uses sel_y.
- R3: ADD (op 0) and SUB (op 1, X minus Y) write X+Y or X-Y to ACC. All four flags come from the adder: C is the carry out, which for SUB means no borrow, and V is the signed overflow.
- R4: AND (op 2), OR (op 3), NOT (op 4, ~Y), XOR (op 5) and MOV (op 14, X) write ACC. N and Z come from the result. C takes the held shifter carry, and V keeps its previous value.
- R5: XORZ (op 13) writes to ACC the count of leading zeros of X^Y, from WIDTH-1 downwards. A zero value gives WIDTH. Flags follow the logical rule of R4.
- R6: LSL (op 6), LSR (op 7), ASR (op 8) and ROR (op 9) shift X by Y[4:0]. They write only SHF and the shifter carry; ACC and the flags are untouched. For a nonzero amount the carry is the last bit shifted out, which for ROR is the new top bit.
- R7: A shift or rotate by 0 leaves the value unchanged in SHF and leaves the shifter carry unchanged.
- R8: The condition codes are 0 EQ, 1 NE, 2 CS, 3 CC, 4 MI, 5 PL, 6 VS, 7 VC, 8 HI, 9 LS, 10 GE, 11 LT, 12 GT, 13 LE, 14 always and 15 never. Code 15 never passes.
- R9: When exec is low or the condition fails, nothing is written: not ACC, SHF, either flag copy, nor the step state.
- R10: With use_stored high the condition tests the stored flags; with it low it tests the current flags.
- R11: With sticky high, a stored-flag write ORs the new flags into the old ones, so no bit can clear.
- R12: With set_flags low, a committed operation updates the current flags but not the stored flags.
- R13: INIT (op 12) loads ACC with Y and SHF with X. Then WIDTH/2 MAC steps (op 10, multiplicand Y) leave ACC = X*Ym + Y0 modulo 2^WIDTH, for a signed or unsigned multiplier.
- R14: After INIT with Y=0 and X=dividend, WIDTH DIV steps (op 11, divisor Y) leave the quotient in SHF and the remainder in ACC.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| exec_i | input | 1 | Operation valid this cycle |
| op_i | input | 4 | Decoded operation code |
| sel_x_i | input | 2 | Source select for operand X |
| sel_y_i | input | 2 | Source select for operand Y |
| reg_a_i | input | WIDTH | Register input A |
| reg_b_i | input | WIDTH | Register input B |
| cond_i | input | 4 | Condition code |
| use_stored_i | input | 1 | Test stored (1) or current (0) flags |
| set_flags_i | input | 1 | Write stored flags on commit |
| sticky_i | input | 1 | Sticky flag write mode |
| alu_res_o | output | WIDTH | Combinational ALU result |
| acc_o | output | WIDTH | Accumulator |
| shf_o | output | WIDTH | Shifter result register |
| flags_o | output | 4 | Stored flags {N,Z,C,V} |
| cond_pass_o | output | 1 | Condition passed |

## Verification
Some properties are checked by assertions on every cycle. A failed condition or an idle cycle must leave ACC, SHF and the stored flags unchanged. A sticky write must never clear a flag bit. A logical operation must keep V, a shift must not touch ACC, and the never code must not pass. The numeric results rest on the bench's scenarios: adder flag edges, the leading-zero counts, the shift carries including the zero amount, the split between current and stored flags, and full multiply and divide sequences against arithmetic computed in the bench.

// File: rtl/alu_pkg.sv
package alu_pkg;
   typedef enum logic [3:0] {
      OP_ADD  = 4'd0,
      OP_SUB  = 4'd1,
      OP_AND  = 4'd2,
      OP_OR   = 4'd3,
      OP_NOT  = 4'd4,
      OP_XOR  = 4'd5,
      OP_LSL  = 4'd6,
      OP_LSR  = 4'd7,
      OP_ASR  = 4'd8,
      OP_ROR  = 4'd9,
      OP_MAC  = 4'd10,
      OP_DIV  = 4'd11,
      OP_INIT = 4'd12,
      OP_XORZ = 4'd13,
      OP_MOV  = 4'd14,
      OP_NOP  = 4'd15
   } alu_op_e;

   typedef enum logic [1:0] {
      SRC_A   = 2'd0,
      SRC_B   = 2'd1,
      SRC_ACC = 2'd2,
      SRC_SHF = 2'd3
   } src_sel_e;

   typedef enum logic [1:0] {
      SH_LSL = 2'd0,
      SH_LSR = 2'd1,
      SH_ASR = 2'd2,
      SH_ROR = 2'd3
   } sh_kind_e;

   localparam int FL_N = 3;
   localparam int FL_Z = 2;
   localparam int FL_C = 1;
   localparam int FL_V = 0;
endpackage

// File: rtl/alu_addsub.sv
module alu_addsub #(
   parameter int WIDTH = 32
) (
   input  logic [WIDTH-1:0] x_i,
   input  logic [WIDTH-1:0] y_i,
   input  logic             sub_i,
   output logic [WIDTH-1:0] sum_o,
   output logic             cout_o,
   output logic             ovf_o
);
   logic [WIDTH-1:0] y_eff;
   logic [WIDTH:0]   wide;

   assign y_eff = sub_i ? ~y_i : y_i;
   assign wide  = {1'b0, x_i} + {1'b0, y_eff} + {{WIDTH{1'b0}}, sub_i};
   assign sum_o  = wide[WIDTH-1:0];
   assign cout_o = wide[WIDTH];
   assign ovf_o  = (x_i[WIDTH-1] == y_eff[WIDTH-1]) && (sum_o[WIDTH-1] != x_i[WIDTH-1]);
endmodule

// File: rtl/alu_shifter.sv
module alu_shifter
   import alu_pkg::*;
#(
   parameter int WIDTH = 32,
   parameter int SW    = $clog2(WIDTH)
) (
   input  logic [WIDTH-1:0] val_i,
   input  logic [SW-1:0]    amt_i,
   input  sh_kind_e         kind_i,
   input  logic             cin_i,
   output logic [WIDTH-1:0] res_o,
   output logic             cout_o
);
   logic [WIDTH:0]   left_w;
   logic [WIDTH:0]   lright_w;
   logic [WIDTH:0]   aright_w;
   logic [WIDTH-1:0] rot_w;
   logic             zero_amt;

   assign zero_amt = (amt_i == '0);
   assign left_w   = {1'b0, val_i} << amt_i;
   assign lright_w = {val_i, 1'b0} >> amt_i;
   assign aright_w = $signed({val_i, 1'b0}) >>> amt_i;
   assign rot_w    = (val_i >> amt_i) | (val_i << (WIDTH - int'(amt_i)));

   always_comb begin
      unique case (kind_i)
         SH_LSL: begin res_o = left_w[WIDTH-1:0];  cout_o = left_w[WIDTH]; end
         SH_LSR: begin res_o = lright_w[WIDTH:1];  cout_o = lright_w[0];   end
         SH_ASR: begin res_o = aright_w[WIDTH:1];  cout_o = aright_w[0];   end
         default: begin res_o = rot_w;             cout_o = rot_w[WIDTH-1]; end
      endcase
      if (zero_amt) begin
         res_o  = val_i;
         cout_o = cin_i;
      end
   end
endmodule

// File: rtl/alu_lzc.sv
module alu_lzc #(
   parameter int WIDTH = 32,
   parameter int CW    = $clog2(WIDTH) + 1
) (
   input  logic [WIDTH-1:0] val_i,
   output logic [CW-1:0]    cnt_o
);
   always_comb begin
      cnt_o = CW'(WIDTH);
      for (int i = 0; i < WIDTH; i++) begin
         if (val_i[i]) cnt_o = CW'(WIDTH - 1 - i);
      end
   end
endmodule

// File: rtl/alu_cond.sv
module alu_cond
   import alu_pkg::*;
(
   input  logic [3:0] code_i,
   input  logic [3:0] flg_i,
   output logic       pass_o
);
   logic n, z, c, v;
   assign n = flg_i[FL_N];
   assign z = flg_i[FL_Z];
   assign c = flg_i[FL_C];
   assign v = flg_i[FL_V];

   always_comb begin
      unique case (code_i)
         4'd0:  pass_o = z;
         4'd1:  pass_o = !z;
         4'd2:  pass_o = c;
         4'd3:  pass_o = !c;
         4'd4:  pass_o = n;
         4'd5:  pass_o = !n;
         4'd6:  pass_o = v;
         4'd7:  pass_o = !v;
         4'd8:  pass_o = c && !z;
         4'd9:  pass_o = !c || z;
         4'd10: pass_o = (n == v);
         4'd11: pass_o = (n != v);
         4'd12: pass_o = !z && (n == v);
         4'd13: pass_o = z || (n != v);
         4'd14: pass_o = 1'b1;
         default: pass_o = 1'b0;
      endcase
   end
endmodule

// File: rtl/cond_alu.sv
module cond_alu
   import alu_pkg::*;
#(
   parameter int WIDTH = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             exec_i,
   input  logic [3:0]       op_i,
   input  logic [1:0]       sel_x_i,
   input  logic [1:0]       sel_y_i,
   input  logic [WIDTH-1:0] reg_a_i,
   input  logic [WIDTH-1:0] reg_b_i,
   input  logic [3:0]       cond_i,
   input  logic             use_stored_i,
   input  logic             set_flags_i,
   input  logic             sticky_i,
   output logic [WIDTH-1:0] alu_res_o,
   output logic [WIDTH-1:0] acc_o,
   output logic [WIDTH-1:0] shf_o,
   output logic [3:0]       flags_o,
   output logic             cond_pass_o
);
   localparam int SW = $clog2(WIDTH);
   localparam int CW = SW + 1;
   localparam int KW = $clog2(WIDTH / 2);

   if (WIDTH < 8 || (WIDTH % 2) != 0 || (1 << SW) != WIDTH) begin : g_bad_width
      $error("cond_alu: WIDTH must be a power of two of at least 8");
   end

   alu_op_e          op_e;
   logic [WIDTH-1:0] acc_q, shf_q;
   logic [3:0]       flg_q, cur_q;
   logic             shc_q, prev_q;
   logic [KW-1:0]    k_q;

   logic [WIDTH-1:0] opx, opy;
   logic [WIDTH-1:0] sum;
   logic             add_c, add_v;
   logic [WIDTH-1:0] sh_res;
   logic             sh_c;
   sh_kind_e         sh_kind;
   logic [CW-1:0]    lz_cnt;
   logic [WIDTH-1:0] res;
   logic             is_arith, is_logic, is_shift;
   logic [3:0]       fl_st, fl_cur;
   logic             commit;
   logic [WIDTH-1:0] booth_base, booth_term;
   logic [WIDTH:0]   rem_sh;
   logic             div_ge;
   logic [WIDTH-1:0] div_diff;

   assign op_e = alu_op_e'(op_i);

   function automatic logic [WIDTH-1:0] pick_src(input logic [1:0] sel,
                                                 input logic [WIDTH-1:0] a,
                                                 input logic [WIDTH-1:0] b,
                                                 input logic [WIDTH-1:0] acc,
                                                 input logic [WIDTH-1:0] shf);
      unique case (src_sel_e'(sel))
         SRC_A:   return a;
         SRC_B:   return b;
         SRC_ACC: return acc;
         default: return shf;
      endcase
   endfunction

   assign opx = pick_src(sel_x_i, reg_a_i, reg_b_i, acc_q, shf_q);
   assign opy = pick_src(sel_y_i, reg_a_i, reg_b_i, acc_q, shf_q);

   alu_addsub #(.WIDTH(WIDTH)) u_addsub (
      .x_i(opx), .y_i(opy), .sub_i(op_e == OP_SUB),
      .sum_o(sum), .cout_o(add_c), .ovf_o(add_v)
   );

   always_comb begin
      unique case (op_e)
         OP_LSL:  sh_kind = SH_LSL;
         OP_LSR:  sh_kind = SH_LSR;
         OP_ASR:  sh_kind = SH_ASR;
         default: sh_kind = SH_ROR;
      endcase
   end

   alu_shifter #(.WIDTH(WIDTH), .SW(SW)) u_shifter (
      .val_i(opx), .amt_i(opy[SW-1:0]), .kind_i(sh_kind), .cin_i(shc_q),
      .res_o(sh_res), .cout_o(sh_c)
   );

   alu_lzc #(.WIDTH(WIDTH), .CW(CW)) u_lzc (
      .val_i(opx ^ opy), .cnt_o(lz_cnt)
   );

   alu_cond u_cond (
      .code_i(cond_i), .flg_i(use_stored_i ? flg_q : cur_q), .pass_o(cond_pass_o)
   );

   // Operation class and combinational result
   always_comb begin
      is_arith = 1'b0;
      is_logic = 1'b0;
      is_shift = 1'b0;
      res      = '0;
      unique case (op_e)
         OP_ADD, OP_SUB: begin is_arith = 1'b1; res = sum;        end
         OP_AND:  begin is_logic = 1'b1; res = opx & opy;          end
         OP_OR:   begin is_logic = 1'b1; res = opx | opy;          end
         OP_NOT:  begin is_logic = 1'b1; res = ~opy;               end
         OP_XOR:  begin is_logic = 1'b1; res = opx ^ opy;          end
         OP_MOV:  begin is_logic = 1'b1; res = opx;                end
         OP_XORZ: begin is_logic = 1'b1; res = WIDTH'(lz_cnt);     end
         OP_LSL, OP_LSR, OP_ASR, OP_ROR: is_shift = 1'b1;
         default: ;
      endcase
   end

   // New flag values for each copy
   always_comb begin
      fl_st  = '0;
      fl_cur = '0;
      fl_st[FL_N]  = res[WIDTH-1];
      fl_st[FL_Z]  = (res == '0);
      fl_cur[FL_N] = res[WIDTH-1];
      fl_cur[FL_Z] = (res == '0);
      if (is_arith) begin
         fl_st[FL_C]  = add_c;
         fl_st[FL_V]  = add_v;
         fl_cur[FL_C] = add_c;
         fl_cur[FL_V] = add_v;
      end else begin
         fl_st[FL_C]  = shc_q;
         fl_st[FL_V]  = flg_q[FL_V];
         fl_cur[FL_C] = shc_q;
         fl_cur[FL_V] = cur_q[FL_V];
      end
   end

   // Radix-4 Booth digit from two multiplier bits and the previous bit
   always_comb begin
      unique case ({shf_q[1:0], prev_q})
         3'b001, 3'b010: booth_base = opy;
         3'b011:         booth_base = opy << 1;
         3'b100:         booth_base = -(opy << 1);
         3'b101, 3'b110: booth_base = -opy;
         default:        booth_base = '0;
      endcase
   end
   assign booth_term = booth_base << {k_q, 1'b0};

   // Restoring divide step
   assign rem_sh   = {acc_q, shf_q[WIDTH-1]};
   assign div_ge   = (rem_sh >= {1'b0, opy});
   assign div_diff = rem_sh[WIDTH-1:0] - opy;

   assign commit = exec_i && cond_pass_o;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         acc_q  <= '0;
         shf_q  <= '0;
         flg_q  <= '0;
         cur_q  <= '0;
         shc_q  <= 1'b0;
         prev_q <= 1'b0;
         k_q    <= '0;
      end else if (commit) begin
         if (is_arith || is_logic) begin
            acc_q <= res;
            cur_q <= fl_cur;
            if (set_flags_i) flg_q <= sticky_i ? (flg_q | fl_st) : fl_st;
         end
         if (is_shift) begin
            shf_q <= sh_res;
            shc_q <= sh_c;
         end
         unique case (op_e)
            OP_INIT: begin
               acc_q  <= opy;
               shf_q  <= opx;
               prev_q <= 1'b0;
               k_q    <= '0;
            end
            OP_MAC: begin
               acc_q  <= acc_q + booth_term;
               shf_q  <= {{2{shf_q[WIDTH-1]}}, shf_q[WIDTH-1:2]};
               prev_q <= shf_q[1];
               k_q    <= k_q + 1'b1;
            end
            OP_DIV: begin
               acc_q <= div_ge ? div_diff : rem_sh[WIDTH-1:0];
               shf_q <= {shf_q[WIDTH-2:0], div_ge};
            end
            default: ;
         endcase
      end
   end

   assign alu_res_o = res;
   assign acc_o     = acc_q;
   assign shf_o     = shf_q;
   assign flags_o   = flg_q;

   // R9
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !exec_i |=> ($stable(acc_q) && $stable(shf_q) && $stable(flg_q) && $stable(cur_q)));
   // R9
   cond_fail_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (exec_i && !cond_pass_o) |=> ($stable(acc_q) && $stable(shf_q) && $stable(flg_q)));
   // R11
   sticky_no_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (exec_i && sticky_i) |=> ((flg_q & $past(flg_q)) == $past(flg_q)));
   // R4
   logic_keeps_v_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (commit && is_logic) |=> (flg_q[FL_V] == $past(flg_q[FL_V])));
   // R6
   shift_keeps_acc_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (exec_i && is_shift) |=> ($stable(acc_q) && $stable(flg_q)));
   // R8
   never_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cond_i == 4'd15) |-> !cond_pass_o);
endmodule

// File: tb/cond_alu_bench.sv
module cond_alu_bench;
   localparam int CLK_PERIOD = 10;
   localparam int W = 32;
   localparam int NVEC = 18;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         exec_i = 1'b0;
   logic [3:0]   op_i = '0;
   logic [1:0]   sel_x_i = 2'd0, sel_y_i = 2'd1;
   logic [W-1:0] reg_a_i = '0, reg_b_i = '0;
   logic [3:0]   cond_i = 4'd14;
   logic         use_stored_i = 1'b1, set_flags_i = 1'b1, sticky_i = 1'b0;
   logic [W-1:0] alu_res_o, acc_o, shf_o;
   logic [3:0]   flags_o;
   logic         cond_pass_o;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   cond_alu #(.WIDTH(W)) u_cond_alu (
      .clk(clk), .rst_n(rst_n), .exec_i(exec_i), .op_i(op_i),
      .sel_x_i(sel_x_i), .sel_y_i(sel_y_i), .reg_a_i(reg_a_i), .reg_b_i(reg_b_i),
      .cond_i(cond_i), .use_stored_i(use_stored_i), .set_flags_i(set_flags_i),
      .sticky_i(sticky_i), .alu_res_o(alu_res_o), .acc_o(acc_o), .shf_o(shf_o),
      .flags_o(flags_o), .cond_pass_o(cond_pass_o)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   // op, x, y, expected acc, expected shf, expected flags {N,Z,C,V}
   localparam logic [135:0] VEC [NVEC] = '{
      {4'd0,  32'h7FFFFFFF, 32'h00000001, 32'h80000000, 32'h00000000, 4'b1001},
      {4'd3,  32'h80000000, 32'h00000001, 32'h80000001, 32'h00000000, 4'b1001},
      {4'd5,  32'h12345678, 32'h12345678, 32'h00000000, 32'h00000000, 4'b0101},
      {4'd0,  32'hFFFFFFFF, 32'h00000001, 32'h00000000, 32'h00000000, 4'b0110},
      {4'd1,  32'h00000005, 32'h00000005, 32'h00000000, 32'h00000000, 4'b0110},
      {4'd1,  32'h00000003, 32'h00000005, 32'hFFFFFFFE, 32'h00000000, 4'b1000},
      {4'd2,  32'hF0F0F0F0, 32'h0FF00000, 32'h00F00000, 32'h00000000, 4'b0000},
      {4'd4,  32'h00000000, 32'h0000FFFF, 32'hFFFF0000, 32'h00000000, 4'b1000},
      {4'd13, 32'h00010000, 32'h00000000, 32'h0000000F, 32'h00000000, 4'b0000},
      {4'd13, 32'h00000005, 32'h00000005, 32'h00000020, 32'h00000000, 4'b0000},
      {4'd14, 32'h80000000, 32'h00000000, 32'h80000000, 32'h00000000, 4'b1000},
      {4'd6,  32'h80000001, 32'h00000001, 32'h80000000, 32'h00000002, 4'b1000},
      {4'd2,  32'h000000FF, 32'h0000000F, 32'h0000000F, 32'h00000002, 4'b0010},
      {4'd7,  32'h80000001, 32'h00000004, 32'h0000000F, 32'h08000000, 4'b0010},
      {4'd8,  32'h80000000, 32'h0000001F, 32'h0000000F, 32'hFFFFFFFF, 4'b0010},
      {4'd9,  32'h00000001, 32'h00000001, 32'h0000000F, 32'h80000000, 4'b0010},
      {4'd9,  32'h12345678, 32'h00000000, 32'h0000000F, 32'h12345678, 4'b0010},
      {4'd3,  32'h00000000, 32'h00000000, 32'h00000000, 32'h12345678, 4'b0110}
   };

   function automatic string tag_of(input logic [3:0] op);
      case (op)
         4'd0, 4'd1: return "R3";
         4'd13:      return "R5";
         4'd6, 4'd7, 4'd8, 4'd9: return "R6";
         default:    return "R4";
      endcase
   endfunction

   task automatic chk(input string tag, input string what,
                      input logic [W-1:0] act, input logic [W-1:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
      end
   endtask

   task automatic run_op(input logic [3:0] op, input logic [1:0] sx, input logic [1:0] sy,
                         input logic [W-1:0] a, input logic [W-1:0] b,
                         input logic [3:0] cc, input logic ust, input logic setf,
                         input logic stk);
      @(negedge clk);
      op_i = op; sel_x_i = sx; sel_y_i = sy; reg_a_i = a; reg_b_i = b;
      cond_i = cc; use_stored_i = ust; set_flags_i = setf; sticky_i = stk;
      exec_i = 1'b1;
      @(negedge clk);
      exec_i = 1'b0;
   endtask

   task automatic finish_run;
      if (!done) begin
         done = 1'b1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      failures++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      logic [W-1:0] exp_v;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk("R1", "acc", acc_o, '0);
      chk("R1", "shf", shf_o, '0);
      chk("R1", "flags", W'(flags_o), '0);
      cond_i = 4'd0; use_stored_i = 1'b0; #1;
      chk("R1", "current Z clear", W'(cond_pass_o), '0);

      for (int i = 0; i < NVEC; i++) begin
         run_op(VEC[i][135:132], 2'd0, 2'd1, VEC[i][131:100], VEC[i][99:68],
                4'd14, 1'b1, 1'b1, 1'b0);
         chk(tag_of(VEC[i][135:132]), "acc", acc_o, VEC[i][67:36]);
         chk(tag_of(VEC[i][135:132]), "shf", shf_o, VEC[i][35:4]);
         chk(tag_of(VEC[i][135:132]), "flags", W'(flags_o), W'(VEC[i][3:0]));
      end

      // R9 failed condition: stored flags 0110, NE fails
      @(negedge clk); cond_i = 4'd1; use_stored_i = 1'b1; #1;
      chk("R8", "NE with Z set", W'(cond_pass_o), 0);
      run_op(4'd0, 2'd0, 2'd1, 32'd1, 32'd1, 4'd1, 1'b1, 1'b1, 1'b0);
      chk("R9", "acc after failed cond", acc_o, 32'h0);
      chk("R9", "flags after failed cond", W'(flags_o), W'(4'b0110));
      run_op(4'd0, 2'd0, 2'd1, 32'd1, 32'd1, 4'd0, 1'b1, 1'b1, 1'b0);
      chk("R8", "EQ pass acc", acc_o, 32'd2);
      chk("R8", "EQ pass flags", W'(flags_o), W'(4'b0000));

      // R12 / R10: no stored flag write, current flags get Z
      run_op(4'd1, 2'd0, 2'd1, 32'd7, 32'd7, 4'd14, 1'b1, 1'b0, 1'b0);
      chk("R12", "acc", acc_o, 32'd0);
      chk("R12", "stored flags kept", W'(flags_o), W'(4'b0000));
      @(negedge clk); cond_i = 4'd0; use_stored_i = 1'b0; #1;
      chk("R10", "EQ on current flags", W'(cond_pass_o), 1);
      use_stored_i = 1'b1; #1;
      chk("R10", "EQ on stored flags", W'(cond_pass_o), 0);

      // R8 never code
      cond_i = 4'd15; #1;
      chk("R8", "NV pass", W'(cond_pass_o), 0);
      run_op(4'd0, 2'd0, 2'd1, 32'd9, 32'd9, 4'd15, 1'b1, 1'b1, 1'b0);
      chk("R8", "NV acc unchanged", acc_o, 32'd0);

      // R11 sticky
      run_op(4'd0, 2'd0, 2'd1, 32'h7FFFFFFF, 32'd1, 4'd14, 1'b1, 1'b1, 1'b1);
      chk("R11", "sticky set", W'(flags_o), W'(4'b1001));
      run_op(4'd0, 2'd0, 2'd1, 32'd1, 32'd1, 4'd14, 1'b1, 1'b1, 1'b1);
      chk("R11", "sticky hold", W'(flags_o), W'(4'b1001));
      run_op(4'd0, 2'd0, 2'd1, 32'd1, 32'd1, 4'd14, 1'b1, 1'b1, 1'b0);
      chk("R11", "non-sticky clears", W'(flags_o), W'(4'b0000));

      // R2 sources: ACC + SHF
      run_op(4'd0, 2'd2, 2'd3, 32'h0, 32'h0, 4'd14, 1'b1, 1'b1, 1'b0);
      chk("R2", "acc+shf", acc_o, 32'h1234567A);
      run_op(4'd14, 2'd1, 2'd0, 32'h11, 32'h22, 4'd14, 1'b1, 1'b1, 1'b0);
      chk("R2", "mov from B", acc_o, 32'h22);

      // R7 shift by zero keeps value and carry (carry currently 1)
      run_op(4'd6, 2'd0, 2'd1, 32'hDEAD0000, 32'd0, 4'd14, 1'b1, 1'b1, 1'b0);
      chk("R7", "shf zero shift", shf_o, 32'hDEAD0000);
      run_op(4'd2, 2'd0, 2'd1, 32'd1, 32'd1, 4'd14, 1'b1, 1'b1, 1'b0);
      chk("R7", "carry kept", W'(flags_o), W'(4'b0010));

      // R13 multiply-accumulate, unsigned-looking and negative multiplier
      run_op(4'd12, 2'd0, 2'd1, 32'h01234567, 32'h00000011, 4'd14, 1'b1, 1'b1, 1'b0);
      for (int s = 0; s < W/2; s++)
         run_op(4'd10, 2'd0, 2'd1, 32'h0, 32'h00ABCDEF, 4'd14, 1'b1, 1'b1, 1'b0);
      exp_v = 32'h01234567 * 32'h00ABCDEF + 32'h11;
      chk("R13", "mac positive", acc_o, exp_v);
      run_op(4'd12, 2'd0, 2'd1, 32'hFFFFFFFD, 32'd100, 4'd14, 1'b1, 1'b1, 1'b0);
      for (int s = 0; s < W/2; s++)
         run_op(4'd10, 2'd0, 2'd1, 32'h0, 32'd7, 4'd14, 1'b1, 1'b1, 1'b0);
      chk("R13", "mac negative multiplier", acc_o, 32'd79);
      run_op(4'd12, 2'd0, 2'd1, 32'h89ABCDEF, 32'h0, 4'd14, 1'b1, 1'b1, 1'b0);
      for (int s = 0; s < W/2; s++)
         run_op(4'd10, 2'd0, 2'd1, 32'h0, 32'hFEDCBA98, 4'd14, 1'b1, 1'b1, 1'b0);
      exp_v = 32'h89ABCDEF * 32'hFEDCBA98;
      chk("R13", "mac wide operands", acc_o, exp_v);

      // R14 divide
      run_op(4'd12, 2'd0, 2'd1, 32'd1000, 32'd0, 4'd14, 1'b1, 1'b1, 1'b0);
      for (int s = 0; s < W; s++)
         run_op(4'd11, 2'd0, 2'd1, 32'h0, 32'd7, 4'd14, 1'b1, 1'b1, 1'b0);
      chk("R14", "quotient", shf_o, 32'd1000 / 32'd7);
      chk("R14", "remainder", acc_o, 32'd1000 % 32'd7);
      run_op(4'd12, 2'd0, 2'd1, 32'hF0000001, 32'd0, 4'd14, 1'b1, 1'b1, 1'b0);
      for (int s = 0; s < W; s++)
         run_op(4'd11, 2'd0, 2'd1, 32'h0, 32'h00012345, 4'd14, 1'b1, 1'b1, 1'b0);
      chk("R14", "quotient large", shf_o, 32'hF0000001 / 32'h00012345);
      chk("R14", "remainder large", acc_o, 32'hF0000001 % 32'h00012345);

      finish_run();
   end
endmodule